// File: doc/BRIEF.md
# Fractional Divider Modulator with Error Accumulation

This block sits in the reference-clock domain of a fractional-N synthesizer. On every reference edge it turns a constant unsigned fractional word into a small signed correction. The multi-modulus divider adds that correction to its integer ratio for the next reference period. Over many periods, the average correction equals the fractional word divided by 2^18.

The modulator is second order. It is built from two cascaded 18-bit accumulators. The carry of the first stage is combined with the carry of the second stage and with a one-cycle-delayed copy of that second carry.

On the same edge, the block forms the quantization error: the input minus the correction scaled by 2^18. It also keeps a running sum of that error. The running sum is the phase-error word for a noise-cancellation DAC. It is updated in lockstep with the divider correction, so the divider path and the cancellation path never drift apart by a cycle.

Top module: `dsm_frac_divmod`

## Requirements
- R1: A synchronous reset clears both accumulators, the delayed carry and all outputs to zero. After reset is released, the output sequence restarts exactly as it does from power-up.
- R2: `div_offset` is a 3-bit two's-complement value that always lies between -1 and +2 inclusive.
- R3: `acc_err` is a 20-bit two's-complement value whose magnitude stays strictly below 2^18 for every input and every cycle.
- R4: `q_err` is a 21-bit two's-complement value. It equals `frac_word` minus 2^18 times `div_offset`, where both `frac_word` and `div_offset` are the values of the same reference edge.
- R5: Each valid `acc_err` equals the previous `acc_err` plus the current `q_err`. The first value after reset is the first `q_err` alone.
- R6: With `frac_word` equal to zero from reset, `div_offset`, `q_err` and `acc_err` all stay at zero.
- R7: Over N cycles from reset, the sum of `div_offset` times 2^18, plus the final `acc_err`, equals N times `frac_word`. Consequently the mean offset equals `frac_word`/2^18 to within 1/N.
- R8: `frac_word` is sampled on each rising edge, and the result appears after that same edge. With `frac_word` = 2^17 from reset, the offsets are 0, 1, 1, 0, repeating every four cycles.
- R9: `err_valid` is low while reset is asserted. It is high from the first edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| frac_word | input | 18 | Unsigned fractional frequency word |
| div_offset | output | 3 | Signed divide-ratio correction, -1 to +2 |
| q_err | output | 21 | Signed quantization error of this cycle |
| acc_err | output | 20 | Signed accumulated error for the cancellation DAC |
| err_valid | output | 1 | High when the outputs carry a modulator result |

## Verification
A corrupted first accumulator or a lost carry shows up within one edge. It breaks the relation between `q_err` and `div_offset`, or it pushes `acc_err` outside its ±2^18 bound. A wrong delayed carry skews the long-run sum of offsets. That skew only shows over thousands of cycles, so a 65,536-cycle mean run checks the exact balance between the offset sum and the final accumulated error. The fixed half-scale pattern pins down the latency, and a mid-run reset confirms that no stale state survives.

// File: rtl/dsm_frac_divmod.sv
module dsm_frac_divmod #(
  parameter int W = 18
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [W-1:0]        frac_word,
  output logic signed [2:0]   div_offset,
  output logic signed [W+2:0] q_err,
  output logic signed [W+1:0] acc_err,
  output logic                err_valid
);
  localparam int QW = W + 3;
  localparam int AW = W + 2;

  logic [W-1:0] stage1_q, stage2_q;
  logic         carry2_d;

  logic [W:0]   sum1, sum2;
  logic         carry1, carry2;
  logic [2:0]   offset_n;
  logic [QW-1:0] offset_scaled;
  logic [QW-1:0] qerr_n;
  logic [QW-1:0] acc_wide;

  assign sum1   = {1'b0, stage1_q} + {1'b0, frac_word};
  assign carry1 = sum1[W];
  assign sum2   = {1'b0, stage2_q} + {1'b0, sum1[W-1:0]};
  assign carry2 = sum2[W];

  assign offset_n      = {2'b00, carry1} + {2'b00, carry2} - {2'b00, carry2_d};
  assign offset_scaled = {{(QW-3){offset_n[2]}}, offset_n} << W;
  assign qerr_n        = {3'b000, frac_word} - offset_scaled;
  assign acc_wide      = {acc_err[AW-1], acc_err} + qerr_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q   <= '0;
      stage2_q   <= '0;
      carry2_d   <= 1'b0;
      div_offset <= '0;
      q_err      <= '0;
      acc_err    <= '0;
      err_valid  <= 1'b0;
    end else begin
      stage1_q   <= sum1[W-1:0];
      stage2_q   <= sum2[W-1:0];
      carry2_d   <= carry2;
      div_offset <= offset_n;
      q_err      <= qerr_n;
      acc_err    <= acc_wide[AW-1:0];
      err_valid  <= 1'b1;
    end
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!err_valid && div_offset == 3'sd0 && acc_err == '0 && q_err == '0));

  assert_offset_range_R2: assert property (@(posedge clk) disable iff (rst)
    err_valid |-> (div_offset >= -3'sd1 && div_offset <= 3'sd2));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    acc_err[AW-1] == acc_err[AW-2]);

  // R5: the running error always equals the first-stage residue minus the held second carry
  assert_err_matches_residue_R5: assert property (@(posedge clk) disable iff (rst)
    err_valid |-> (acc_err == ({2'b00, stage1_q} - {1'b0, carry2_d, {W{1'b0}}})));

  assert_valid_after_reset_R9: assert property (@(posedge clk)
    (!rst && $past(!rst)) |-> err_valid);
endmodule

// File: tb/dsm_frac_divmod_tb.sv
module dsm_frac_divmod_tb;
  localparam int W = 18;
  localparam longint SCALE = longint'(1) << W;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [W-1:0]        frac_word = '0;
  logic signed [2:0]   div_offset;
  logic signed [W+2:0] q_err;
  logic signed [W+1:0] acc_err;
  logic                err_valid;

  int checks = 0;
  int errors = 0;
  longint prev_acc = 0;
  longint off_sum = 0;

  always #2.5 clk = ~clk;

  dsm_frac_divmod #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .frac_word(frac_word),
    .div_offset(div_offset), .q_err(q_err), .acc_err(acc_err), .err_valid(err_valid)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [W-1:0] x);
    @(negedge clk);
    rst = 1'b1;
    frac_word = x;
    @(negedge clk);
    @(negedge clk);
    chk(err_valid == 1'b0, "R9 valid in reset", longint'(err_valid), 0);
    chk(div_offset == 0 && acc_err == 0 && q_err == 0, "R1 outputs cleared",
        longint'(acc_err), 0);
    rst = 1'b0;
    prev_acc = 0;
    off_sum = 0;
  endtask

  task automatic run_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      longint off, qe, ae;
      @(negedge clk);
      off = longint'(div_offset);
      qe  = longint'(q_err);
      ae  = longint'(acc_err);
      chk(off >= -1 && off <= 2, "R2 offset range", off, 0);
      chk(ae > -SCALE && ae < SCALE, "R3 acc bound", ae, 0);
      chk(qe == longint'(frac_word) - off * SCALE, "R4 error word", qe,
          longint'(frac_word) - off * SCALE);
      chk(ae == prev_acc + qe, "R5 accumulation", ae, prev_acc + qe);
      prev_acc = ae;
      off_sum += off;
    end
  endtask

  task automatic t_reset_state;
    do_reset('0);
    @(negedge clk);
    chk(err_valid == 1'b1, "R9 valid after release", longint'(err_valid), 1);
  endtask

  task automatic t_zero_input;
    do_reset('0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      chk(div_offset == 0 && q_err == 0 && acc_err == 0, "R6 zero input",
          longint'(acc_err) + longint'(div_offset), 0);
    end
  endtask

  task automatic t_half_pattern;
    int exp_seq[4] = '{0, 1, 1, 0};
    do_reset(W'(1) << (W - 1));
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(longint'(div_offset) == exp_seq[i % 4], "R8 half-scale pattern",
          longint'(div_offset), exp_seq[i % 4]);
    end
  endtask

  task automatic t_reset_midrun;
    int exp_seq[4] = '{0, 1, 1, 0};
    do_reset(W'(12345));
    run_cycles(57);
    do_reset(W'(1) << (W - 1));
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(longint'(div_offset) == exp_seq[i % 4], "R1 restart after reset",
          longint'(div_offset), exp_seq[i % 4]);
    end
  endtask

  task automatic t_max_input;
    do_reset({W{1'b1}});
    run_cycles(4096);
  endtask

  task automatic t_varying_input;
    logic [W-1:0] vals[5] = '{W'(1), W'(131071), W'(200003), W'(262143), W'(77)};
    do_reset(vals[0]);
    for (int k = 0; k < 40; k++) begin
      frac_word = vals[k % 5];
      run_cycles(37);
    end
  endtask

  task automatic t_mean;
    longint n = 65536;
    longint x = 74564;
    do_reset(W'(x));
    run_cycles(int'(n));
    chk(off_sum * SCALE + prev_acc == n * x, "R7 sum balance",
        off_sum * SCALE + prev_acc, n * x);
    chk(off_sum == (n * x) / SCALE || off_sum == (n * x) / SCALE + 1, "R7 mean",
        off_sum, (n * x) / SCALE);
  endtask

  initial begin
    t_reset_state();
    t_zero_input();
    t_half_pattern();
    t_reset_midrun();
    t_max_input();
    t_varying_input();
    t_mean();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule